// File: doc/BRIEF.md
# Dual-Mode FIFO Read Output Stage

This block is the read-side output register of a synchronous FIFO. It sits between the storage array and the reader. The array tells it whether it holds data (`arr_nonempty`) and shows the word at its head (`arr_head`). The stage answers with a pop strobe (`arr_pop`) each time it takes that word into its output register (`rd_data`).

A static mode input selects one of two read behaviours, and both share the same register. In fall-through mode the stage preloads itself: the first available word lands in the register on the same rising edge that raises the flag (`rd_avail`, read as "output ready"). Later words move in only when the reader asks for them. In standard mode nothing is preloaded. The flag (read as "not empty", active high) rises on the second rising edge after the array reports data. A word moves into the register only on an accepted read.

The controller is a four-state machine:
- `ST_EMPTY`: flag low, both modes.
- `ST_LOADED`: fall-through mode, flag high, register valid.
- `ST_SEEN`: standard mode, data seen for one edge, flag still low.
- `ST_READY`: standard mode, flag high.

Transitions:
- `ST_EMPTY` to `ST_LOADED` on data in fall-through mode, with a pop.
- `ST_EMPTY` to `ST_SEEN` on data in standard mode.
- `ST_LOADED` to `ST_EMPTY` on a read while the array is empty.
- `ST_SEEN` to `ST_READY` if data is still present; `ST_SEEN` to `ST_EMPTY` if it is gone.
- `ST_READY` to `ST_SEEN` on a read, with a pop.

Top module: `fifo_ostage`

## Requirements
- R1: While `rst_n` is low, `rd_avail` is 0, `rd_data` is 0 and `arr_pop` is 0. The mode input `mode_fwft` (1 = fall-through, 0 = standard) changes only while `rst_n` is low.
- R2: In fall-through mode with `rd_avail` low and `arr_nonempty` high, `arr_pop` is high in that cycle. On the following edge `rd_data` takes `arr_head` and `rd_avail` goes high, whatever `rd_req` is.
- R3: In fall-through mode with `rd_avail` high and `rd_req` low, `arr_pop` stays low. `rd_data` and `rd_avail` hold.
- R4: In fall-through mode with `rd_avail` high, `rd_req` high and `arr_nonempty` high, `arr_pop` is high. On the edge `rd_data` takes `arr_head` and `rd_avail` stays high.
- R5: In fall-through mode with `rd_avail` high, `rd_req` high and `arr_nonempty` low, `arr_pop` stays low. On the edge `rd_avail` drops to 0 and `rd_data` keeps its last word.
- R6: In standard mode, once `arr_nonempty` goes high with `rd_avail` low, `rd_avail` rises on the second rising edge. No pop is issued and `rd_data` is unchanged.
- R7: In standard mode with `rd_avail` high and `rd_req` high, `arr_pop` is high. On the edge `rd_data` takes `arr_head` and `rd_avail` drops to 0. If `arr_nonempty` is high on the next edge, `rd_avail` rises again on that edge.
- R8: A read request while `rd_avail` is low is ignored. In standard mode no pop is issued and `rd_data` is unchanged. In fall-through mode with the array empty, nothing changes.
- R9: In standard mode, if `arr_nonempty` falls before the second edge, `rd_avail` stays low.
- R10: Every load of `rd_data` goes with exactly one cycle of `arr_pop`, and `rd_data` never changes without a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fwft | input | 1 | 1 = fall-through mode, 0 = standard mode; static outside reset |
| arr_nonempty | input | 1 | Storage array holds at least one word |
| arr_head | input | DATA_W | Word at the head of the array |
| rd_req | input | 1 | Read request from the consumer |
| arr_pop | output | 1 | Pop strobe to the array, combinational, taken at the next edge |
| rd_avail | output | 1 | Output-ready (fall-through) or not-empty (standard) flag |
| rd_data | output | DATA_W | Registered output word |

## Verification
The bench targets the places where the two modes differ:
- The preload edge in fall-through mode. A design that waited for a read would leave the flag low with data present.
- The two-edge flag delay in standard mode. An off-by-one would raise the flag one edge early or late.
- A fall-through read against an empty array. A wrong design would pop nothing yet change the data, or keep the flag high.
- A standard-mode data pulse that vanishes after one edge. A design without requalification would raise a flag over an empty array.

It also issues reads while the flag is low. A design that accepted them would pop, or overwrite the register, where no word was offered.

// File: rtl/ostage_pkg.sv
package ostage_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_LOADED = 2'd1,
        ST_SEEN   = 2'd2,
        ST_READY  = 2'd3
    } ostage_state_e;
endpackage

// File: rtl/ostage_ctrl.sv
module ostage_ctrl
    import ostage_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_fwft,
    input  logic arr_nonempty,
    input  logic rd_req,
    output logic pop,
    output logic avail
);
    ostage_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY:  if (arr_nonempty) state_d = mode_fwft ? ST_LOADED : ST_SEEN;
            ST_LOADED: if (rd_req && !arr_nonempty) state_d = ST_EMPTY;
            ST_SEEN:   state_d = arr_nonempty ? ST_READY : ST_EMPTY;
            ST_READY:  if (rd_req) state_d = ST_SEEN;
            default:   state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        pop   = 1'b0;
        avail = 1'b0;
        unique case (state_q)
            ST_EMPTY:  pop = mode_fwft && arr_nonempty;
            ST_LOADED: begin
                avail = 1'b1;
                pop   = rd_req && arr_nonempty;
            end
            ST_SEEN:   pop = 1'b0;
            ST_READY:  begin
                avail = 1'b1;
                pop   = rd_req && arr_nonempty;
            end
            default:   pop = 1'b0;
        endcase
        pop = pop && rst_n;
    end

    assert_mode_static_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_fwft));
    assert_fwft_preload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fwft && !avail && arr_nonempty) |-> pop ##1 avail);
    assert_fwft_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fwft && avail && !rd_req) |-> !pop ##1 avail);
    assert_fwft_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fwft && avail && rd_req && !arr_nonempty) |=> !avail);
    assert_std_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fwft && avail && rd_req && arr_nonempty) |-> pop ##1 !avail);
    assert_std_no_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fwft && !avail) |-> !pop);
endmodule

// File: rtl/ostage_dreg.sv
module ostage_dreg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n)    dout <= '0;
        else if (load) dout <= din;
    end

    assert_load_on_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dout == $past(din)));
    assert_hold_no_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dout));
endmodule

// File: rtl/fifo_ostage.sv
module fifo_ostage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fwft,
    input  logic              arr_nonempty,
    input  logic [DATA_W-1:0] arr_head,
    input  logic              rd_req,
    output logic              arr_pop,
    output logic              rd_avail,
    output logic [DATA_W-1:0] rd_data
);
    ostage_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_fwft    (mode_fwft),
        .arr_nonempty (arr_nonempty),
        .rd_req       (rd_req),
        .pop          (arr_pop),
        .avail        (rd_avail)
    );

    ostage_dreg #(.DATA_W(DATA_W)) u_dreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (arr_pop),
        .din   (arr_head),
        .dout  (rd_data)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rd_avail && rd_data == '0));
endmodule

// File: tb/fifo_ostage_tb.sv
module fifo_ostage_tb;
    localparam int DW = 32;

    typedef struct packed {
        logic          rst;
        logic          mode;
        logic          ne;
        logic          rd;
        logic [DW-1:0] head;
        logic          e_pop;
        logic          e_avail;
        logic [DW-1:0] e_data;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,1'b0,1'b0,32'h0,        1'b0,1'b0,32'h0,        4'd8},  // R8 idle
        '{1'b0,1'b1,1'b1,1'b0,32'hA1A1_0001,1'b1,1'b1,32'hA1A1_0001,4'd2},  // R2 preload
        '{1'b0,1'b1,1'b1,1'b0,32'hA2A2_0002,1'b0,1'b1,32'hA1A1_0001,4'd3},  // R3 hold
        '{1'b0,1'b1,1'b1,1'b1,32'hA2A2_0002,1'b1,1'b1,32'hA2A2_0002,4'd4},  // R4 read
        '{1'b0,1'b1,1'b1,1'b1,32'hA3A3_0003,1'b1,1'b1,32'hA3A3_0003,4'd4},  // R4 back-to-back
        '{1'b0,1'b1,1'b0,1'b1,32'hA4A4_0004,1'b0,1'b0,32'hA3A3_0003,4'd5},  // R5 drain
        '{1'b0,1'b1,1'b0,1'b1,32'hA4A4_0004,1'b0,1'b0,32'hA3A3_0003,4'd8},  // R8 read while low
        '{1'b0,1'b1,1'b1,1'b1,32'hA5A5_0005,1'b1,1'b1,32'hA5A5_0005,4'd2},  // R2 refill
        '{1'b1,1'b0,1'b1,1'b0,32'hFFFF_FFFF,1'b0,1'b0,32'h0,        4'd1},  // R1 reset, mode switch
        '{1'b0,1'b0,1'b0,1'b1,32'h0,        1'b0,1'b0,32'h0,        4'd8},  // R8 std empty read
        '{1'b0,1'b0,1'b1,1'b0,32'hB1B1_0001,1'b0,1'b0,32'h0,        4'd6},  // R6 first edge
        '{1'b0,1'b0,1'b1,1'b1,32'hB1B1_0001,1'b0,1'b1,32'h0,        4'd6},  // R6 second edge, read ignored
        '{1'b0,1'b0,1'b1,1'b0,32'hB1B1_0001,1'b0,1'b1,32'h0,        4'd6},  // R6 no preload
        '{1'b0,1'b0,1'b1,1'b1,32'hB1B1_0001,1'b1,1'b0,32'hB1B1_0001,4'd7},  // R7 read
        '{1'b0,1'b0,1'b1,1'b1,32'hB2B2_0002,1'b0,1'b1,32'hB1B1_0001,4'd7},  // R7 requalify
        '{1'b0,1'b0,1'b1,1'b1,32'hB2B2_0002,1'b1,1'b0,32'hB2B2_0002,4'd7},  // R7 second read
        '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b0,1'b0,32'hB2B2_0002,4'd7},  // R7 array gone
        '{1'b0,1'b0,1'b1,1'b0,32'hB3B3_0003,1'b0,1'b0,32'hB2B2_0002,4'd9},  // R9 pulse seen
        '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b0,1'b0,32'hB2B2_0002,4'd9},  // R9 pulse gone
        '{1'b0,1'b0,1'b0,1'b0,32'h0,        1'b0,1'b0,32'hB2B2_0002,4'd9}   // R9 stays low
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_fwft = 1'b1;
    logic          arr_nonempty = 1'b0;
    logic [DW-1:0] arr_head = '0;
    logic          rd_req = 1'b0;
    logic          arr_pop;
    logic          rd_avail;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fifo_ostage #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_fwft(mode_fwft),
        .arr_nonempty(arr_nonempty), .arr_head(arr_head), .rd_req(rd_req),
        .arr_pop(arr_pop), .rd_avail(rd_avail), .rd_data(rd_data)
    );

    task automatic chk(input string what, input int r, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
        end
    endtask

    initial begin
        fork
            begin
                // R1: reset state with data offered during reset
                arr_nonempty = 1'b1;
                arr_head     = 32'hDEAD_BEEF;
                repeat (3) @(posedge clk);
                #2;
                chk("reset pop", 1, DW'(arr_pop), '0);
                chk("reset avail", 1, DW'(rd_avail), '0);
                chk("reset data", 1, rd_data, '0);
                @(negedge clk);
                arr_nonempty = 1'b0;
                rst_n = 1'b1;
                @(posedge clk);
                for (int i = 0; i < NV; i++) begin
                    @(negedge clk);
                    rst_n        = ~VEC[i].rst;
                    mode_fwft    = VEC[i].mode;
                    arr_nonempty = VEC[i].ne;
                    rd_req       = VEC[i].rd;
                    arr_head     = VEC[i].head;
                    #2;
                    chk("pop", int'(VEC[i].req), DW'(arr_pop), DW'(VEC[i].e_pop));
                    @(posedge clk);
                    #2;
                    chk("avail", int'(VEC[i].req), DW'(rd_avail), DW'(VEC[i].e_avail));
                    chk("data", int'(VEC[i].req), rd_data, VEC[i].e_data);
                end
                // R10: a pop-free standard window leaves the register untouched
                @(negedge clk);
                rd_req = 1'b1;
                arr_nonempty = 1'b0;
                arr_head = 32'h1234_5678;
                #2;
                chk("R10 no pop", 10, DW'(arr_pop), '0);
                @(posedge clk);
                #2;
                chk("R10 data held", 10, rd_data, 32'hB2B2_0002);
            end
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL R1 watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule